// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into a framed serial bit stream on one output line. A frame opens with a low start bit, carries the data bits least significant first, may add one parity bit, and closes with high stop bits. The character length, the parity, the stop duration and the clock factor are set on configuration inputs. The clock factor says how many pulses of the transmit tick enable make one bit period.

Software-side logic writes a character into a single holding register while the ready flag is high. The engine moves the character into its shift register as soon as the shifter is idle, and that frees the holding register for the next character. An empty flag reports that the holding register and the shifter have both drained. A break input forces the line low for as long as it is held.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high (idle), `txRdy` is 1 and `txEmpty` is 1; whenever nothing is being sent and break is off, the line stays high.
- R2: A write (`wrEn` high while `txRdy` is 1) stores `wrData` and makes `txRdy` 0 from the next cycle on. A write while `txRdy` is 0 is ignored, and the stored character is unchanged.
- R3: The frame is a start bit of 0, then the data bits from bit 0 upward, then the parity bit if it is enabled, then stop bits of 1. `charLen` selects the data width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R4: When `parityEn` is 1, a parity bit is sent. With `paritySel` at 1 the parity is even, so the data bits plus the parity bit hold an even number of ones. With `paritySel` at 0 the parity is odd.
- R5: `stopCode` sets the stop duration: 01 gives 1 bit period, 10 gives 1.5 bit periods, 11 gives 2 bit periods, and 00 is treated as 1. With a clock factor of x1, code 10 gives 2 bit periods.
- R6: `clkFactor` sets the number of `tickEn` pulses per bit: 01 gives 1, 10 gives 16 and 11 gives 64. Code 00 is treated as x1. The line changes only on a clock where `tickEn` is 1, except when a frame starts.
- R7: `txEmpty` is 1 only when the holding register is empty and no frame is in progress.
- R8: While `sendBreak` is 1 the line is 0. Frame timing continues underneath, and the frame resumes in place when break is released.
- R9: The holding register moves into the shifter on the first clock on which the shifter is idle, and the start bit appears after that clock edge. The configuration is captured at that moment. Consecutive frames are separated by exactly one idle clock after the stop time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Transmit tick enable |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Character to send |
| charLen | input | 2 | Character length code |
| parityEn | input | 1 | Parity bit enable |
| paritySel | input | 1 | 1 = even parity, 0 = odd parity |
| stopCode | input | 2 | Stop duration code |
| clkFactor | input | 2 | Ticks-per-bit code |
| sendBreak | input | 1 | Force the line low |
| txLine | output | 1 | Serial output, idle high |
| txRdy | output | 1 | Holding register can accept a character |
| txEmpty | output | 1 | Holding register and shifter both empty |

## Verification
The bench runs characters through every length code and both parity senses, and chooses data values so that a swapped bit order, a dropped top bit or an inverted parity produces a different line waveform. All three clock factors are run. The x1 factor uses a sparse tick, so that advancing on plain clocks shows up as an error. All stop codes are run, including 1.5 at x1 and x16, which separates half-bit timing from whole-bit timing. Further runs send back-to-back characters with a rejected write in between, assert break in the middle of a frame, and change the configuration during a frame; these show whether handover, write blocking, the break override and configuration capture are correct.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int MAX_CHAR = 8;
  localparam int FRAME_W  = MAX_CHAR + 2;
  localparam int TICK_W   = 8;
  localparam int CNT_W    = 4;

  typedef struct packed {
    logic [1:0] charLen;
    logic       parityEn;
    logic       paritySel;
    logic [1:0] stopCode;
    logic [1:0] clkFactor;
  } txCfg_t;

  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;

  function automatic logic [TICK_W-1:0] bitTicksOf(logic [1:0] f);
    case (f)
      2'b10:   return TICK_W'(16);
      2'b11:   return TICK_W'(64);
      default: return TICK_W'(1);
    endcase
  endfunction

  function automatic logic [TICK_W-1:0] stopTicksOf(logic [1:0] s, logic [TICK_W-1:0] b);
    case (s)
      2'b10:   return (b == TICK_W'(1)) ? TICK_W'(2) : TICK_W'(b + (b >> 1));
      2'b11:   return TICK_W'(b << 1);
      default: return b;
    endcase
  endfunction
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      holdValid,
  input  txCfg_t    cfg,
  output txStrobe_t strb,
  output logic      busy
);
  logic              inStop;
  logic [TICK_W-1:0] tickCnt, bitTicks, stopLen, limit;
  logic [CNT_W-1:0]  bitsLeft;
  logic              lastTick;

  always_comb begin
    limit      = inStop ? stopLen : bitTicks;
    lastTick   = tickEn && (tickCnt == limit - TICK_W'(1));
    strb.load  = !busy && holdValid;
    strb.shift = busy && lastTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      inStop   <= 1'b0;
      tickCnt  <= '0;
      bitsLeft <= '0;
      bitTicks <= TICK_W'(1);
      stopLen  <= TICK_W'(1);
    end else if (strb.load) begin
      busy     <= 1'b1;
      inStop   <= 1'b0;
      tickCnt  <= '0;
      bitsLeft <= CNT_W'(6) + CNT_W'(cfg.charLen) + CNT_W'(cfg.parityEn);
      bitTicks <= bitTicksOf(cfg.clkFactor);
      stopLen  <= stopTicksOf(cfg.stopCode, bitTicksOf(cfg.clkFactor));
    end else if (busy && tickEn) begin
      if (lastTick) begin
        tickCnt <= '0;
        if (inStop) begin
          busy <= 1'b0;
        end else begin
          if (bitsLeft == CNT_W'(1)) inStop <= 1'b1;
          bitsLeft <= bitsLeft - CNT_W'(1);
        end
      end else begin
        tickCnt <= tickCnt + TICK_W'(1);
      end
    end
  end
endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAX_CHAR-1:0] wrData,
  input  txCfg_t              cfg,
  input  txStrobe_t           strb,
  output logic                holdValid,
  output logic                lineBit
);
  logic [MAX_CHAR-1:0] holdReg, masked;
  logic [FRAME_W-1:0]  shReg, frameVec;
  logic                parityBit;
  int                  nBits;

  always_comb begin
    nBits  = 5 + int'(cfg.charLen);
    masked = '0;
    for (int i = 0; i < MAX_CHAR; i++)
      if (i < nBits) masked[i] = holdReg[i];
    parityBit = (^masked) ^ ~cfg.paritySel;
    frameVec    = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < MAX_CHAR; i++)
      if (i < nBits) frameVec[i+1] = masked[i];
    if (cfg.parityEn) frameVec[nBits+1] = parityBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdReg   <= '0;
      shReg     <= '1;
    end else begin
      if (strb.load) begin
        holdValid <= 1'b0;
        shReg     <= frameVec;
      end else begin
        if (wrEn && !holdValid) begin
          holdValid <= 1'b1;
          holdReg   <= wrData;
        end
        if (strb.shift) shReg <= {1'b1, shReg[FRAME_W-1:1]};
      end
    end
  end

  assign lineBit = shReg[0];
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic [MAX_CHAR-1:0] wrData,
  input  logic [1:0]          charLen,
  input  logic                parityEn,
  input  logic                paritySel,
  input  logic [1:0]          stopCode,
  input  logic [1:0]          clkFactor,
  input  logic                sendBreak,
  output logic                txLine,
  output logic                txRdy,
  output logic                txEmpty
);
  txCfg_t    cfg;
  txStrobe_t strb;
  logic      busy, holdValid, lineBit;

  assign cfg = '{charLen: charLen, parityEn: parityEn, paritySel: paritySel,
                 stopCode: stopCode, clkFactor: clkFactor};

  sertx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .holdValid(holdValid),
    .cfg(cfg), .strb(strb), .busy(busy)
  );

  sertx_dpath dpath_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cfg(cfg),
    .strb(strb), .holdValid(holdValid), .lineBit(lineBit)
  );

  assign txLine  = lineBit & ~sendBreak;
  assign txRdy   = ~holdValid;
  assign txEmpty = ~holdValid & ~busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic sendBreak,
  input logic txLine,
  input logic txRdy,
  input logic txEmpty
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !sendBreak) |-> txLine);
  assert_write_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txRdy) |=> !txRdy);
  assert_empty_needs_room_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txRdy);
  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txLine);
endmodule

bind sertx_top sertx_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .sendBreak(sendBreak),
  .txLine(txLine), .txRdy(txRdy), .txEmpty(txEmpty)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] charLen = 2'b11, stopCode = 2'b01, clkFactor = 2'b10;
  logic parityEn = 1'b0, paritySel = 1'b0, sendBreak = 1'b0;
  logic txLine, txRdy, txEmpty;

  always #2 clk = ~clk;

  sertx_top dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .charLen(charLen), .parityEn(parityEn), .paritySel(paritySel),
    .stopCode(stopCode), .clkFactor(clkFactor), .sendBreak(sendBreak),
    .txLine(txLine), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  int checks = 0, failures = 0, cycles = 0, tickDiv = 1, tickCnt = 0;
  bit finished = 0;
  string curTag = "R1";

  // behavioural reference state
  bit mHoldValid = 0, mBusy = 0;
  logic [7:0] mHold = '0;
  int segLvl[$], segTk[$];
  int mRem = 0;

  task automatic buildFrame(input logic [7:0] d);
    int n, f, st, ones;
    n = 5 + int'(charLen);
    f = (clkFactor == 2'b10) ? 16 : (clkFactor == 2'b11) ? 64 : 1;
    st = (stopCode == 2'b11) ? 2*f : (stopCode == 2'b10) ? ((f == 1) ? 2 : (3*f)/2) : f;
    segLvl.delete(); segTk.delete();
    segLvl.push_back(0); segTk.push_back(f);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      segLvl.push_back(int'(d[i])); segTk.push_back(f);
      ones += int'(d[i]);
    end
    if (parityEn) begin
      segLvl.push_back(paritySel ? (ones % 2) : 1 - (ones % 2));
      segTk.push_back(f);
    end
    segLvl.push_back(1); segTk.push_back(st);
  endtask

  always @(posedge clk) begin
    bit oldValid;
    cycles++;
    if (!rstN) begin
      mHoldValid = 0; mBusy = 0; mRem = 0;
      segLvl.delete(); segTk.delete();
    end else begin
      oldValid = mHoldValid;
      if (mBusy) begin
        if (tickEn) begin
          mRem--;
          if (mRem == 0) begin
            void'(segLvl.pop_front()); void'(segTk.pop_front());
            if (segLvl.size() == 0) mBusy = 0; else mRem = segTk[0];
          end
        end
      end else if (oldValid) begin
        buildFrame(mHold);
        mBusy = 1; mHoldValid = 0; mRem = segTk[0];
      end
      if (wrEn && !oldValid) begin
        mHold = wrData; mHoldValid = 1;
      end
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // compare on every falling edge; inputs move only at negedge+1
  always @(negedge clk) begin
    logic expLine, expRdy, expEmpty;
    if (rstN && !finished) begin
      expLine  = sendBreak ? 1'b0 : (mBusy ? 1'(segLvl[0]) : 1'b1);
      expRdy   = !mHoldValid;
      expEmpty = !mHoldValid && !mBusy;
      checks++;
      if (txLine !== expLine || txRdy !== expRdy || txEmpty !== expEmpty) begin
        failures++;
        $display("FAIL %s at cycle %0d: actual line/rdy/empty=%b%b%b expected=%b%b%b",
                 curTag, cycles, txLine, txRdy, txEmpty, expLine, expRdy, expEmpty);
      end
    end
    #1;
    tickCnt++;
    tickEn = (tickCnt % tickDiv) == 0;
  end

  task automatic sendChar(input logic [7:0] d);
    @(negedge clk);
    while (!txRdy) @(negedge clk);
    #1 wrEn = 1; wrData = d;
    @(negedge clk);
    #1 wrEn = 0;
  endtask

  task automatic waitDrain();
    @(negedge clk);
    while (!txEmpty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] cl, input logic pe, input logic ps,
                        input logic [1:0] sc, input logic [1:0] cf, input int div);
    @(negedge clk);
    #1 charLen = cl; parityEn = pe; paritySel = ps; stopCode = sc; clkFactor = cf;
    tickDiv = div;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (txLine !== 1'b1 || txRdy !== 1'b1 || txEmpty !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: actual=%b%b%b expected=111", txLine, txRdy, txEmpty);
    end
    // R3 R4: 8 bits, even parity, x16
    curTag = "R3_R4_even8";
    setCfg(2'b11, 1, 1, 2'b01, 2'b10, 1);
    sendChar(8'hA5); waitDrain();
    // R3 R4: 5 bits, odd parity, x1 with sparse ticks, R5 1.5 -> 2 at x1, R6
    curTag = "R5_R6_x1_odd5";
    setCfg(2'b00, 1, 0, 2'b10, 2'b01, 3);
    sendChar(8'hF3); waitDrain();
    // R3 R5 R6: 7 bits, no parity, 2 stops, x64
    curTag = "R3_R5_R6_x64";
    setCfg(2'b10, 0, 0, 2'b11, 2'b11, 1);
    sendChar(8'hCE); waitDrain();
    // R5: 1.5 stops at x16, 6 bits
    curTag = "R5_half_stop";
    setCfg(2'b01, 1, 1, 2'b10, 2'b10, 2);
    sendChar(8'h2D); waitDrain();
    // R5 R6: code 00 fallbacks
    curTag = "R5_R6_code00";
    setCfg(2'b11, 0, 0, 2'b00, 2'b00, 2);
    sendChar(8'h81); waitDrain();
    // R2 R7 R9: back to back, rejected write while full
    curTag = "R2_R7_R9_b2b";
    setCfg(2'b11, 1, 0, 2'b01, 2'b10, 1);
    sendChar(8'h11);
    sendChar(8'h22);
    @(negedge clk);
    #1 wrEn = 1; wrData = 8'hEE;   // hold full: must be ignored
    @(negedge clk);
    #1 wrEn = 0;
    sendChar(8'h33);
    waitDrain();
    // R8: break in mid-frame
    curTag = "R8_break";
    sendChar(8'h5A);
    repeat (40) @(negedge clk);
    #1 sendBreak = 1;
    repeat (25) @(negedge clk);
    #1 sendBreak = 0;
    waitDrain();
    // R9: configuration changed during a frame does not alter it
    curTag = "R9_cfg_capture";
    sendChar(8'h96);
    repeat (10) @(negedge clk);
    #1 charLen = 2'b00; parityEn = 0; clkFactor = 2'b01;
    waitDrain();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule